// File: doc/BRIEF.md
# Stepped Transmit Level Controller

This block chooses the attenuation setting of a transmit output amplifier. An analog peak detector outside the block compares the sensed output peak with two thresholds and reports two flags: the peak is under the lower threshold, or it is over the upper threshold. The block turns these flags into a small attenuation code. Each code step is 3 dB, so the default eight levels span 0 to 21 dB.

Adaptation runs only at the start of a frame. A frame-start pulse opens a short window covering the first two bits. A divider splits each bit into quarters, and the code is adjusted once at the end of every quarter, which gives eight adjustments per frame. The window then closes and the code holds its value through the rest of the frame and any idle time that follows. The next frame adapts again from that held value.

The window closes on whichever comes first: the last decision, or the second bit strobe. A decision is one step up, one step down or no change. The code saturates at both ends and never wraps.

Top module: `tx_level_ctrl`

## Requirements
- R1: After reset the code is at its maximum, LEVELS-1 (7 with defaults, meaning 21 dB of attenuation). Code value n stands for n times 3 dB.
- R2: At a decision with only the low-peak flag set, the code drops by one (gain goes up). At 0 it stays at 0.
- R3: At a decision with only the high-peak flag set, the code rises by one (gain goes down). At LEVELS-1 it stays at LEVELS-1.
- R4: At a decision with neither flag set, the code is unchanged.
- R5: When both flags are set at a decision, the high-peak case wins and the code rises by one, saturating at LEVELS-1.
- R6: Decisions come every QTR_CYCLES clocks. The first lands on the clock edge QTR_CYCLES edges after the edge that samples frameStart. The code changes on no other edge.
- R7: A frame makes at most WINDOW_BITS*QTRS_PER_BIT decisions (eight with defaults). After the window closes, both flags are ignored and the code holds until the next frameStart.
- R8: The window also closes on the WINDOW_BITS-th bitStrobe after frameStart, even if fewer decisions were made. A bitStrobe restarts the quarter divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | One-cycle pulse at the first bit of a frame; opens the window |
| bitStrobe | input | 1 | One-cycle pulse at each bit boundary |
| peakLow | input | 1 | Sensed peak is below the low threshold |
| peakHigh | input | 1 | Sensed peak is above the high threshold |
| attenCode | output | CODE_W | Attenuation code, 3 dB per step |

## Verification
The bench builds the block with QTR_CYCLES=3 and keeps the defaults of eight levels, four quarters per bit and a two-bit window. A whole frame is then only 24 clocks long. That makes it cheap to sweep every starting code against every flag combination, checking the code after each single decision and on every edge in between. The short quarter also makes it easy to bring the second bit strobe in early, so the bench can check that the window closes after two decisions. It also checks that flags held between frames leave the code untouched.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  // Strobes passed from the window control to the code datapath
  typedef struct packed {
    logic decide;      // apply one adaptation decision on this edge
    logic windowOpen;  // adaptation window currently open
  } tlcStrobe_t;
endpackage

// File: rtl/tlc_ctrl.sv
module tlc_ctrl
  import tlc_pkg::*;
#(
  parameter int QTR_CYCLES   = 3000,
  parameter int QTRS_PER_BIT = 4,
  parameter int WINDOW_BITS  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       bitStrobe,
  output tlcStrobe_t strobes
);
  localparam int DECISIONS = WINDOW_BITS * QTRS_PER_BIT;
  localparam int PH_W      = $clog2(QTR_CYCLES + 1);
  localparam int DC_W      = $clog2(DECISIONS + 1);
  localparam int BT_W      = $clog2(WINDOW_BITS + 1);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(QTR_CYCLES - 1);
  localparam logic [DC_W-1:0] DC_LAST  = DC_W'(DECISIONS - 1);
  localparam logic [BT_W-1:0] BT_LAST  = BT_W'(WINDOW_BITS - 1);

  logic            active;
  logic [PH_W-1:0] phase;
  logic [DC_W-1:0] decCount;
  logic [BT_W-1:0] bitsSeen;
  logic            terminal;
  logic            lastDecision;
  logic            lastBit;

  assign terminal     = (phase == PH_LAST);
  assign lastDecision = terminal && (decCount == DC_LAST);
  assign lastBit      = bitStrobe && (bitsSeen == BT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      phase    <= '0;
      decCount <= '0;
      bitsSeen <= '0;
    end else if (frameStart) begin
      active   <= 1'b1;
      phase    <= '0;
      decCount <= '0;
      bitsSeen <= '0;
    end else if (active) begin
      phase <= (terminal || bitStrobe) ? '0 : phase + 1'b1;
      if (terminal)  decCount <= decCount + 1'b1;
      if (bitStrobe) bitsSeen <= bitsSeen + 1'b1;
      if (lastDecision || lastBit) active <= 1'b0;
    end
  end

  always_comb begin
    strobes.windowOpen = active;
    strobes.decide     = active && terminal && !frameStart;
  end

  // R7: an open window never has the full decision count behind it
  a_r7_decision_cap : assert property (@(posedge clk) disable iff (!rstN)
    active |-> (decCount < DC_W'(DECISIONS)));
  // R8: an open window has seen fewer than WINDOW_BITS bit strobes
  a_r8_bit_cap : assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitsSeen < BT_W'(WINDOW_BITS)));
  // R6: the window opens only in response to a frame start
  a_r6_open_on_frame : assert property (@(posedge clk) disable iff (!rstN)
    (!active ##1 active) |-> $past(frameStart));
endmodule

// File: rtl/tlc_datapath.sv
module tlc_datapath
  import tlc_pkg::*;
#(
  parameter int LEVELS = 8,
  localparam int CODE_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlcStrobe_t        strobes,
  input  logic              peakLow,
  input  logic              peakHigh,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] CODE_MAX = CODE_W'(LEVELS - 1);

  logic atTop;
  logic atBottom;
  logic [CODE_W-1:0] codeNext;

  assign atTop    = (code == CODE_MAX);
  assign atBottom = (code == '0);

  always_comb begin
    codeNext = code;
    if (strobes.decide) begin
      if (peakHigh) begin
        if (!atTop) codeNext = code + 1'b1;   // too loud: more attenuation
      end else if (peakLow) begin
        if (!atBottom) codeNext = code - 1'b1; // too quiet: less attenuation
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) code <= CODE_MAX;
    else       code <= codeNext;
  end

  // R6: without a decision strobe the code holds
  a_r6_hold_between : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.decide |=> $stable(code));
  // R7: closed window leaves the code untouched whatever the flags do
  a_r7_closed_hold : assert property (@(posedge clk) disable iff (!rstN)
    !strobes.windowOpen |=> $stable(code));
  // R5: high flag wins, one step up below the top
  a_r5_high_wins : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decide && peakHigh && code != CODE_MAX) |=> (code == $past(code) + 1'b1));
  // R2: low flag alone steps down above the bottom
  a_r2_step_down : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decide && peakLow && !peakHigh && code != '0) |=> (code == $past(code) - 1'b1));
  // R4: no flag leaves the code alone
  a_r4_no_flag : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decide && !peakLow && !peakHigh) |=> $stable(code));
  // R3: saturation at the top
  a_r3_top_sat : assert property (@(posedge clk) disable iff (!rstN)
    (code == CODE_MAX && peakHigh) |=> (code == CODE_MAX));
endmodule

// File: rtl/tx_level_ctrl.sv
module tx_level_ctrl
  import tlc_pkg::*;
#(
  parameter int LEVELS       = 8,
  parameter int QTR_CYCLES   = 3000,
  parameter int QTRS_PER_BIT = 4,
  parameter int WINDOW_BITS  = 2,
  localparam int CODE_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              bitStrobe,
  input  logic              peakLow,
  input  logic              peakHigh,
  output logic [CODE_W-1:0] attenCode
);
  tlcStrobe_t strobes;

  tlc_ctrl #(
    .QTR_CYCLES  (QTR_CYCLES),
    .QTRS_PER_BIT(QTRS_PER_BIT),
    .WINDOW_BITS (WINDOW_BITS)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .bitStrobe (bitStrobe),
    .strobes   (strobes)
  );

  tlc_datapath #(
    .LEVELS(LEVELS)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .peakLow (peakLow),
    .peakHigh(peakHigh),
    .code    (attenCode)
  );

  // R1: code is at maximum on the first edge after reset release
  a_r1_reset_max : assert property (@(posedge clk)
    $rose(rstN) |-> (attenCode == CODE_W'(LEVELS - 1)));
endmodule

// File: tb/tx_level_ctrl_tb.sv
module tx_level_ctrl_tb_top;
  localparam int LEVELS = 8;
  localparam int Q      = 3;
  localparam int QPB    = 4;
  localparam int WB     = 2;
  localparam int NDEC   = QPB * WB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 1'b0;
  logic bitStrobe = 1'b0;
  logic peakLow = 1'b0;
  logic peakHigh = 1'b0;
  logic [2:0] attenCode;

  int errors = 0;
  int checks = 0;
  int expCode;
  bit finished = 0;

  always #5 clk = ~clk;

  tx_level_ctrl #(
    .LEVELS(LEVELS), .QTR_CYCLES(Q), .QTRS_PER_BIT(QPB), .WINDOW_BITS(WB)
  ) dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .bitStrobe(bitStrobe),
    .peakLow(peakLow), .peakHigh(peakHigh), .attenCode(attenCode)
  );

  task automatic check(input string req, input int exp);
    checks++;
    if (int'(attenCode) != exp) begin
      errors++;
      $display("FAIL %s: attenCode=%0d expected=%0d at %0t", req, attenCode, exp, $time);
    end
  endtask

  function automatic int stepModel(input int c, input bit lo, input bit hi);
    if (hi) return (c < LEVELS - 1) ? c + 1 : c;
    if (lo) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  function automatic string tagOf(input bit lo, input bit hi);
    if (hi && lo) return "R5";
    if (hi) return "R3";
    if (lo) return "R2";
    return "R4";
  endfunction

  // Full frame: flags for decision j come from bit j of the masks.
  task automatic runFrame(input logic [NDEC-1:0] lowMask, input logic [NDEC-1:0] highMask);
    frameStart = 1'b1;
    @(posedge clk); @(negedge clk);
    frameStart = 1'b0;
    for (int n = 1; n <= NDEC * Q; n++) begin
      bitStrobe = (n % (QPB * Q) == 0);
      if ((n - 1) % Q == 0) begin
        peakLow  = lowMask[(n - 1) / Q];
        peakHigh = highMask[(n - 1) / Q];
      end
      @(posedge clk); @(negedge clk);
      bitStrobe = 1'b0;
      if (n % Q == 0) begin
        expCode = stepModel(expCode, peakLow, peakHigh);
        check(tagOf(peakLow, peakHigh), expCode);
      end else begin
        check("R6", expCode);
      end
    end
    peakLow = 1'b0;
    peakHigh = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expCode = LEVELS - 1;
    check("R1", expCode);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", expCode);

    // R2: walk down to zero and saturate on the eighth decision
    runFrame('1, '0);
    check("R2", 0);

    // R7: flags held after the window leave the code alone
    peakHigh = 1'b1;
    peakLow = 1'b1;
    repeat (5 * Q) begin
      @(negedge clk);
      check("R7", expCode);
    end
    bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    check("R7", expCode);
    peakHigh = 1'b0;
    peakLow = 1'b0;

    // Sweep every starting code against every flag combination
    for (int s = 0; s < LEVELS; s++) begin
      for (int combo = 0; combo < 4; combo++) begin
        runFrame('1, '0);
        runFrame('0, NDEC'((1 << s) - 1));
        check("R3", s);
        runFrame(combo[0] ? '1 : '0, combo[1] ? '1 : '0);
      end
    end

    // R8: early second bit strobe closes the window after two decisions
    runFrame('1, '0);
    peakHigh = 1'b1;
    frameStart = 1'b1;
    @(posedge clk); @(negedge clk);
    frameStart = 1'b0;
    for (int n = 1; n <= 6 * Q; n++) begin
      bitStrobe = (n == Q) || (n == 2 * Q);
      @(posedge clk); @(negedge clk);
      bitStrobe = 1'b0;
      if (n == Q) check("R8", 1);
      if (n > 2 * Q) check("R8", 2);
    end
    peakHigh = 1'b0;
    expCode = 2;

    // R6: first decision lands exactly Q edges after the frame start edge
    peakHigh = 1'b1;
    frameStart = 1'b1;
    @(posedge clk); @(negedge clk);
    frameStart = 1'b0;
    for (int n = 1; n < Q; n++) begin
      @(posedge clk); @(negedge clk);
      check("R6", 2);
    end
    @(posedge clk); @(negedge clk);
    check("R6", 3);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule